// File: doc/BRIEF.md
# Serial Register Programming Slave

This block receives configuration words from a host controller over a three-pin serial link (a serial clock, a data line and an enable line). It places each word into one of five internal registers: control, receive divider ratio, reference divider ratio, transmit divider ratio and auxiliary. The destination depends on two things together: the level the enable line held while the word was shifted in, and address bits at the top of the word. For the auxiliary register only a single address bit is needed.

The serial pins are oversampled in the system clock domain. A frame is the stretch of time between two changes of the enable line. A word takes effect only if exactly sixteen serial clock rising edges fell inside that stretch. The control register is decoded into a power mode and per-mode enables for the receive and transmit chains, three mute flags, a battery-detector power-off flag, a speaker gain code with its gain in dB, a status-pin source select and clock-output settings. The auxiliary register is decoded into an oscillator capacitor select, a carrier-detect threshold (code and dB), a battery-detect level select and test bits.

Divider ratios are staged. Writes to the receive, transmit and reference registers land in shadow copies. All three ratios are handed to the dividers together when the next control word is accepted, and a one-cycle load strobe marks that moment.

Top module: `rf_serial_regif`

## Requirements
- R1: Words are 16 bits, shifted in MSB first on rising edges of `ser_clk`. A word is accepted only when the enable line changes level and exactly 16 rising edges occurred since its previous change. A frame of 15 or 17 edges changes no output.
- R2: A frame shifted with `ser_en` low is routed by word bits 15:14: 00 goes to control, 01 to the receive ratio, 10 to the reference ratio and 11 to the transmit ratio.
- R3: A frame shifted with `ser_en` high is written to the auxiliary register when word bit 15 is 1. When bit 15 is 0 the frame is discarded.
- R4: Control bits 13:12 give `pwr_mode` (00 receive, 01 active, 10 standby, 11 inactive). `rx_chain_en` is 1 in receive and active modes. `tx_chain_en` is 1 in active mode only.
- R5: Control bit 11 drives `batt_det_off`. Bits 10, 9 and 8 drive `mute_comp`, `mute_exp` and `mute_spk`, where 1 means muted.
- R6: Control bits 7:4 appear on `spk_code`. `spk_gain_db` is -18 + 2 x code, in two's complement, so the range runs from -18 at 0000 to +12 at 1111.
- R7: Control bit 3 drives `stat_sel` (0 carrier detect, 1 lock detect). Bit 2 drives `clko_mute`. `clko_div` equals 2 + bits 1:0.
- R8: Auxiliary bits 14:9 drive `osc_cap`, bits 8:5 drive `cd_code`, bits 4:2 drive `batt_sel` and bits 1:0 drive `test_sel`. `cd_thr_db` is -20 + 2 x `cd_code`, in two's complement.
- R9: Ratio words update shadows only. `rx_ratio` and `tx_ratio` (word bits 13:0), and `ref_ratio` (bits 11:0) with `ref_mode` (bits 13:12), all change together when a control word is accepted. `div_load` pulses for exactly one cycle per accepted control word.
- R10: After reset the outputs read as follows: mode inactive, every mute and flag 0, gain code 0, clock divisor 5, threshold code 1010, other auxiliary fields 0, receive ratio 7215, transmit ratio 9966, reference ratio 2048 with mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock from host |
| ser_data | input | 1 | Serial data, MSB first |
| ser_en | input | 1 | Enable line; its level selects the register group, its edges end frames |
| pwr_mode | output | 2 | Decoded power mode |
| rx_chain_en | output | 1 | Receive chain enable |
| tx_chain_en | output | 1 | Transmit-side enable |
| batt_det_off | output | 1 | Battery detector power-off |
| mute_comp | output | 1 | Compressor mute |
| mute_exp | output | 1 | Expander mute |
| mute_spk | output | 1 | Speaker mute |
| spk_code | output | 4 | Speaker gain code |
| spk_gain_db | output | 6 | Speaker gain in dB, two's complement |
| stat_sel | output | 1 | Status pin source select |
| clko_mute | output | 1 | Clock output mute |
| clko_div | output | 3 | Clock output divisor (2 to 5) |
| osc_cap | output | 6 | Oscillator capacitor select |
| cd_code | output | 4 | Carrier-detect threshold code |
| cd_thr_db | output | 6 | Carrier-detect threshold in dB, two's complement |
| batt_sel | output | 3 | Battery-detect level select |
| test_sel | output | 2 | Test mode bits |
| rx_ratio | output | 14 | Active receive divider ratio |
| tx_ratio | output | 14 | Active transmit divider ratio |
| ref_ratio | output | 12 | Active reference divider ratio |
| ref_mode | output | 2 | Active reference mode bits |
| div_load | output | 1 | One-cycle strobe when ratios are loaded |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a two-stage input synchronizer, and reset ratios of 7215, 9966 and 2048. With these values the reset ratios are distinct numbers, so a premature or partial ratio load shows up at once. The serial clock is slow against the system clock, so each frame, including 15- and 17-edge frames, reaches the frame logic as separate edges through the synchronizer. Random frame lengths, enable levels and address bits, checked against a model of shadows and active copies, cover every routing path, the discarded auxiliary frames and the extremes of the gain and threshold codes.

// File: rtl/rfsi_pkg.sv
package rfsi_pkg;

  typedef enum logic [1:0] {
    PM_RX       = 2'b00,
    PM_ACTIVE   = 2'b01,
    PM_STANDBY  = 2'b10,
    PM_INACTIVE = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    DST_CTRL = 2'b00,
    DST_RX   = 2'b01,
    DST_REF  = 2'b10,
    DST_TX   = 2'b11
  } dst_e;

  typedef struct packed {
    dst_e        addr;
    pwr_mode_e   mode;
    logic        batt_off;
    logic        m_comp;
    logic        m_exp;
    logic        m_spk;
    logic [3:0]  gain;
    logic        stat_sel;
    logic        ck_mute;
    logic [1:0]  ck_div;
  } ctrl_word_t;

  typedef struct packed {
    logic        sel;
    logic [5:0]  cap;
    logic [3:0]  cd;
    logic [2:0]  batt;
    logic [1:0]  test;
  } aux_word_t;

  localparam logic [15:0] CTRL_RST = 16'h3003;
  localparam logic [15:0] AUX_RST  = 16'h0140;

endpackage

// File: rtl/rfsi_shift.sv
module rfsi_shift #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_en,
  output logic              cm_valid,
  output logic              cm_level,
  output logic [WORD_W-1:0] cm_word
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(WORD_W + 2);

  logic [SYNC_STAGES-1:0] s_clk, s_dat, s_en;
  logic clk_q, en_q;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_clk <= '0;
      s_dat <= '0;
      s_en  <= '0;
    end else begin
      s_clk <= {s_clk[SYNC_STAGES-2:0], ser_clk};
      s_dat <= {s_dat[SYNC_STAGES-2:0], ser_data};
      s_en  <= {s_en[SYNC_STAGES-2:0], ser_en};
    end
  end

  logic clk_s, dat_s, en_s, rise, en_edge;
  assign clk_s   = s_clk[SYNC_STAGES-1];
  assign dat_s   = s_dat[SYNC_STAGES-1];
  assign en_s    = s_en[SYNC_STAGES-1];
  assign rise    = clk_s & ~clk_q;
  assign en_edge = en_s ^ en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q    <= 1'b0;
      en_q     <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      cm_valid <= 1'b0;
      cm_level <= 1'b0;
      cm_word  <= '0;
    end else begin
      clk_q    <= clk_s;
      en_q     <= en_s;
      cm_valid <= 1'b0;
      if (en_edge) begin
        cm_valid <= (cnt == CNT_W'(WORD_W));
        cm_level <= en_q;
        cm_word  <= shreg;
        cnt      <= '0;
      end else if (rise) begin
        shreg <= {shreg[WORD_W-2:0], dat_s};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
    end
  end

  // R1: the edge counter saturates just past a full word
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(CNT_MAX));

  // R1: two commits never come back to back
  a_r1_commit_gap: assert property (@(posedge clk) disable iff (rst)
    cm_valid |=> !cm_valid);

endmodule

// File: rtl/rfsi_bank.sv
module rfsi_bank
  import rfsi_pkg::*;
#(
  parameter int          WORD_W  = 16,
  parameter int          REF_W   = 12,
  parameter logic [13:0] RX_RST  = 14'd7215,
  parameter logic [13:0] TX_RST  = 14'd9966,
  parameter logic [11:0] REF_RST = 12'd2048
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cm_valid,
  input  logic                cm_level,
  input  logic [WORD_W-1:0]   cm_word,
  output ctrl_word_t          ctrl_q,
  output aux_word_t           aux_q,
  output logic [WORD_W-3:0]   rx_ratio,
  output logic [WORD_W-3:0]   tx_ratio,
  output logic [REF_W-1:0]    ref_ratio,
  output logic [1:0]          ref_mode,
  output logic                div_load
);
  localparam int RAT_W = WORD_W - 2;

  logic [RAT_W-1:0] rx_sh, tx_sh, ref_sh;
  dst_e dst;
  logic wr_low;
  assign dst    = dst_e'(cm_word[WORD_W-1 -: 2]);
  assign wr_low = cm_valid & ~cm_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= ctrl_word_t'(CTRL_RST);
      aux_q     <= aux_word_t'(AUX_RST);
      rx_sh     <= RX_RST;
      tx_sh     <= TX_RST;
      ref_sh    <= {2'b00, REF_RST};
      rx_ratio  <= RX_RST;
      tx_ratio  <= TX_RST;
      ref_ratio <= REF_RST;
      ref_mode  <= 2'b00;
      div_load  <= 1'b0;
    end else begin
      div_load <= 1'b0;
      if (wr_low) begin
        unique case (dst)
          DST_CTRL: begin
            ctrl_q    <= ctrl_word_t'(cm_word);
            rx_ratio  <= rx_sh;
            tx_ratio  <= tx_sh;
            ref_ratio <= ref_sh[REF_W-1:0];
            ref_mode  <= ref_sh[RAT_W-1 -: 2];
            div_load  <= 1'b1;
          end
          DST_RX:  rx_sh  <= cm_word[RAT_W-1:0];
          DST_REF: ref_sh <= cm_word[RAT_W-1:0];
          DST_TX:  tx_sh  <= cm_word[RAT_W-1:0];
          default: ;
        endcase
      end
      if (cm_valid && cm_level && cm_word[WORD_W-1])
        aux_q <= aux_word_t'(cm_word);
    end
  end

  // R2: control changes only after a low-level commit addressed to it
  a_r2_ctrl_source: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q != $past(ctrl_q)) |->
      $past(cm_valid && !cm_level && cm_word[WORD_W-1 -: 2] == 2'b00));

  // R3: auxiliary changes only after a high-level commit with bit 15 set
  a_r3_aux_source: assert property (@(posedge clk) disable iff (rst)
    (aux_q != $past(aux_q)) |->
      $past(cm_valid && cm_level && cm_word[WORD_W-1]));

  // R9: active ratios move only together with the load strobe
  a_r9_atomic_rx: assert property (@(posedge clk) disable iff (rst)
    (rx_ratio != $past(rx_ratio)) |-> div_load);
  a_r9_atomic_tx: assert property (@(posedge clk) disable iff (rst)
    (tx_ratio != $past(tx_ratio)) |-> div_load);
  a_r9_atomic_ref: assert property (@(posedge clk) disable iff (rst)
    ({ref_mode, ref_ratio} != $past({ref_mode, ref_ratio})) |-> div_load);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    div_load |=> !div_load);

endmodule

// File: rtl/rfsi_decode.sv
module rfsi_decode
  import rfsi_pkg::*;
(
  input  ctrl_word_t  ctrl_q,
  input  aux_word_t   aux_q,
  output logic [1:0]  pwr_mode,
  output logic        rx_chain_en,
  output logic        tx_chain_en,
  output logic        batt_det_off,
  output logic        mute_comp,
  output logic        mute_exp,
  output logic        mute_spk,
  output logic [3:0]  spk_code,
  output logic [5:0]  spk_gain_db,
  output logic        stat_sel,
  output logic        clko_mute,
  output logic [2:0]  clko_div,
  output logic [5:0]  osc_cap,
  output logic [3:0]  cd_code,
  output logic [5:0]  cd_thr_db,
  output logic [2:0]  batt_sel,
  output logic [1:0]  test_sel
);
  always_comb begin
    pwr_mode     = ctrl_q.mode;
    rx_chain_en  = (ctrl_q.mode == PM_RX) || (ctrl_q.mode == PM_ACTIVE);
    tx_chain_en  = (ctrl_q.mode == PM_ACTIVE);
    batt_det_off = ctrl_q.batt_off;
    mute_comp    = ctrl_q.m_comp;
    mute_exp     = ctrl_q.m_exp;
    mute_spk     = ctrl_q.m_spk;
    spk_code     = ctrl_q.gain;
    spk_gain_db  = ({2'b00, ctrl_q.gain} << 1) - 6'd18;
    stat_sel     = ctrl_q.stat_sel;
    clko_mute    = ctrl_q.ck_mute;
    clko_div     = {1'b0, ctrl_q.ck_div} + 3'd2;
    osc_cap      = aux_q.cap;
    cd_code      = aux_q.cd;
    cd_thr_db    = ({2'b00, aux_q.cd} << 1) - 6'd20;
    batt_sel     = aux_q.batt;
    test_sel     = aux_q.test;
  end
endmodule

// File: rtl/rf_serial_regif.sv
module rf_serial_regif
  import rfsi_pkg::*;
#(
  parameter int          WORD_W      = 16,
  parameter int          SYNC_STAGES = 2,
  parameter int          REF_W       = 12,
  parameter logic [13:0] RX_RST      = 14'd7215,
  parameter logic [13:0] TX_RST      = 14'd9966,
  parameter logic [11:0] REF_RST     = 12'd2048
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_en,
  output logic [1:0]  pwr_mode,
  output logic        rx_chain_en,
  output logic        tx_chain_en,
  output logic        batt_det_off,
  output logic        mute_comp,
  output logic        mute_exp,
  output logic        mute_spk,
  output logic [3:0]  spk_code,
  output logic [5:0]  spk_gain_db,
  output logic        stat_sel,
  output logic        clko_mute,
  output logic [2:0]  clko_div,
  output logic [5:0]  osc_cap,
  output logic [3:0]  cd_code,
  output logic [5:0]  cd_thr_db,
  output logic [2:0]  batt_sel,
  output logic [1:0]  test_sel,
  output logic [13:0] rx_ratio,
  output logic [13:0] tx_ratio,
  output logic [11:0] ref_ratio,
  output logic [1:0]  ref_mode,
  output logic        div_load
);
  logic              cm_valid, cm_level;
  logic [WORD_W-1:0] cm_word;
  ctrl_word_t        ctrl_q;
  aux_word_t         aux_q;

  rfsi_shift #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_en(ser_en), .cm_valid(cm_valid), .cm_level(cm_level),
    .cm_word(cm_word));

  rfsi_bank #(.WORD_W(WORD_W), .REF_W(REF_W), .RX_RST(RX_RST),
              .TX_RST(TX_RST), .REF_RST(REF_RST)) u_bank (
    .clk(clk), .rst(rst), .cm_valid(cm_valid), .cm_level(cm_level),
    .cm_word(cm_word), .ctrl_q(ctrl_q), .aux_q(aux_q),
    .rx_ratio(rx_ratio), .tx_ratio(tx_ratio), .ref_ratio(ref_ratio),
    .ref_mode(ref_mode), .div_load(div_load));

  rfsi_decode u_decode (
    .ctrl_q(ctrl_q), .aux_q(aux_q), .pwr_mode(pwr_mode),
    .rx_chain_en(rx_chain_en), .tx_chain_en(tx_chain_en),
    .batt_det_off(batt_det_off), .mute_comp(mute_comp),
    .mute_exp(mute_exp), .mute_spk(mute_spk), .spk_code(spk_code),
    .spk_gain_db(spk_gain_db), .stat_sel(stat_sel),
    .clko_mute(clko_mute), .clko_div(clko_div), .osc_cap(osc_cap),
    .cd_code(cd_code), .cd_thr_db(cd_thr_db), .batt_sel(batt_sel),
    .test_sel(test_sel));

  // R4: the transmit side never runs without the receive chain
  a_r4_tx_needs_rx: assert property (@(posedge clk) disable iff (rst)
    tx_chain_en |-> rx_chain_en);

  // R4: both chains are off in the two low-power modes
  a_r4_low_power_off: assert property (@(posedge clk) disable iff (rst)
    pwr_mode[1] |-> (!rx_chain_en && !tx_chain_en));

endmodule

// File: tb/tb_rf_serial_regif.sv
module tb_rf_serial_regif;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0;
  logic [1:0]  pwr_mode;
  logic        rx_chain_en, tx_chain_en, batt_det_off;
  logic        mute_comp, mute_exp, mute_spk, stat_sel, clko_mute;
  logic [3:0]  spk_code, cd_code;
  logic [5:0]  spk_gain_db, cd_thr_db, osc_cap;
  logic [2:0]  clko_div, batt_sel;
  logic [1:0]  test_sel, ref_mode;
  logic [13:0] rx_ratio, tx_ratio;
  logic [11:0] ref_ratio;
  logic        div_load;

  always #2 clk = ~clk;

  rf_serial_regif dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_en(ser_en), .pwr_mode(pwr_mode), .rx_chain_en(rx_chain_en),
    .tx_chain_en(tx_chain_en), .batt_det_off(batt_det_off),
    .mute_comp(mute_comp), .mute_exp(mute_exp), .mute_spk(mute_spk),
    .spk_code(spk_code), .spk_gain_db(spk_gain_db), .stat_sel(stat_sel),
    .clko_mute(clko_mute), .clko_div(clko_div), .osc_cap(osc_cap),
    .cd_code(cd_code), .cd_thr_db(cd_thr_db), .batt_sel(batt_sel),
    .test_sel(test_sel), .rx_ratio(rx_ratio), .tx_ratio(tx_ratio),
    .ref_ratio(ref_ratio), .ref_mode(ref_mode), .div_load(div_load));

  int checks = 0, errors = 0;
  int loads = 0, exp_loads = 0;
  bit done = 1'b0;

  logic [15:0] e_ctrl = 16'h3003, e_aux = 16'h0140;
  logic [13:0] sh_rx = 14'd7215, sh_tx = 14'd9966, sh_ref = 14'd2048;
  logic [13:0] a_rx = 14'd7215, a_tx = 14'd9966, a_ref = 14'd2048;

  always @(posedge clk) if (!rst && div_load) loads++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int db6(input int v);
    return v & 6'h3f;
  endfunction

  task automatic check_all(input string ctx);
    int m;
    m = int'(e_ctrl[13:12]);
    chk({ctx, " R4 mode"}, pwr_mode, m);
    chk({ctx, " R4 rx_en"}, rx_chain_en, (m == 0 || m == 1) ? 1 : 0);
    chk({ctx, " R4 tx_en"}, tx_chain_en, (m == 1) ? 1 : 0);
    chk({ctx, " R5 flags"}, {batt_det_off, mute_comp, mute_exp, mute_spk},
        e_ctrl[11:8]);
    chk({ctx, " R6 code"}, spk_code, e_ctrl[7:4]);
    chk({ctx, " R6 db"}, spk_gain_db, db6(2 * int'(e_ctrl[7:4]) - 18));
    chk({ctx, " R7 sel/mute"}, {stat_sel, clko_mute}, e_ctrl[3:2]);
    chk({ctx, " R7 div"}, clko_div, int'(e_ctrl[1:0]) + 2);
    chk({ctx, " R8 cap"}, osc_cap, e_aux[14:9]);
    chk({ctx, " R8 cd"}, cd_code, e_aux[8:5]);
    chk({ctx, " R8 cd db"}, cd_thr_db, db6(2 * int'(e_aux[8:5]) - 20));
    chk({ctx, " R8 batt/test"}, {batt_sel, test_sel}, e_aux[4:0]);
    chk({ctx, " R9 rx"}, rx_ratio, a_rx);
    chk({ctx, " R9 tx"}, tx_ratio, a_tx);
    chk({ctx, " R9 ref"}, {ref_mode, ref_ratio}, a_ref);
    chk({ctx, " R9 loads"}, loads, exp_loads);
  endtask

  task automatic send(input bit lvl, input logic [15:0] w, input int nb);
    if (ser_en !== !lvl) begin
      ser_en = !lvl;
      repeat (8) @(negedge clk);
    end
    ser_en = lvl;
    repeat (8) @(negedge clk);
    for (int i = nb - 1; i >= 0; i--) begin
      ser_data = (i < 16) ? w[i] : 1'b0;
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
    ser_en = !lvl;
    repeat (12) @(negedge clk);
    if (nb == 16) begin
      if (!lvl) begin
        case (w[15:14])
          2'b00: begin
            e_ctrl = w; a_rx = sh_rx; a_tx = sh_tx; a_ref = sh_ref;
            exp_loads++;
          end
          2'b01: sh_rx = w[13:0];
          2'b10: sh_ref = w[13:0];
          default: sh_tx = w[13:0];
        endcase
      end else if (w[15]) e_aux = w;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5213));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 mode", pwr_mode, 3);
    chk("R10 clko_div", clko_div, 5);
    chk("R10 cd_code", cd_code, 10);
    chk("R10 rx", rx_ratio, 7215);
    chk("R10 tx", tx_ratio, 9966);
    chk("R10 ref", {ref_mode, ref_ratio}, 2048);
    chk("R10 flags", {batt_det_off, mute_comp, mute_exp, mute_spk, spk_code}, 0);
    check_all("R10 reset");

    // R2/R9: ratio words stay in shadows until a control write
    send(1'b0, {2'b01, 14'd1000}, 16);
    send(1'b0, {2'b11, 14'd500}, 16);
    send(1'b0, {2'b10, 2'b01, 12'd300}, 16);
    chk("R9 rx held", rx_ratio, 7215);
    chk("R9 ref held", ref_ratio, 2048);
    check_all("R9 shadow");
    send(1'b0, 16'h1a5e, 16);
    chk("R9 rx loaded", rx_ratio, 1000);
    chk("R9 ref loaded", {ref_mode, ref_ratio}, {2'b01, 12'd300});
    check_all("R2 ctrl");

    // R4 every power mode
    for (int m = 0; m < 4; m++) begin
      send(1'b0, {2'b00, 2'(m), 12'h0f1}, 16);
      check_all("R4 mode sweep");
    end

    // R1 short and long frames are dropped
    send(1'b0, 16'h1ff3, 15);
    check_all("R1 short");
    send(1'b0, 16'h1ff3, 17);
    check_all("R1 long");
    send(1'b0, {2'b01, 14'd77}, 15);
    send(1'b0, 16'h0000, 16);
    chk("R1 short ratio", rx_ratio, 1000);

    // R3 auxiliary routing
    send(1'b1, 16'h7fff, 16);
    check_all("R3 bit15 clear");
    send(1'b1, 16'hffff, 16);
    chk("R8 cd max db", cd_thr_db, db6(10));
    check_all("R3 aux");
    send(1'b1, 16'h8000, 16);
    chk("R8 cd min db", cd_thr_db, db6(-20));
    // R6 gain extremes
    send(1'b0, 16'h00f0, 16);
    chk("R6 max db", spk_gain_db, 12);
    send(1'b0, 16'h0000, 16);
    chk("R6 min db", spk_gain_db, db6(-18));

    // random mix
    for (int k = 0; k < 50; k++) begin
      int r, nb;
      r  = int'($urandom % 8);
      nb = (r == 0) ? 15 : (r == 1) ? 17 : 16;
      send(1'($urandom % 2), 16'($urandom), nb);
      check_all("random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule